// File: doc/BRIEF.md
# Dual-Channel Front-End Frame Decoder

This block sits behind a gigabit deserializer and takes one 20-bit frame per bunch crossing. Each frame carries a two-bit alignment marker and the samples of two digitizer channels. Every channel sample is a 7-bit floating-point energy code with a 2-bit capacitor tag. The block watches the marker to decide whether the link is framed. It then splits each accepted frame into two 9-bit channel words.

While the link is framed, each channel's capacitor tag must step forward by one, modulo 4, from frame to frame. When the tag breaks that rotation, the block raises an error bit for that channel on that frame and takes the new tag as its reference. The registered words, a valid strobe and the two error bits then go to the lookup-table linearization stage that follows.

Frame layout, with bit 19 as the most significant bit: bits 19:18 hold the marker, which is good when it equals 2'b10. Bits 17:9 are channel A and bits 8:0 are channel B. Within each channel word, the upper two bits are the capacitor tag and the lower seven bits are the energy code.

Top module: `fe_frame_decoder`

## Requirements
- R1: After reset, `locked`, `dec_vld`, `a_err` and `b_err` are 0 and both channel words are 0.
- R2: The block declares lock on the 8th consecutive frame (with `frm_vld` high) whose marker bits 19:18 equal 2'b10. That frame is also the first one with `dec_vld` high.
- R3: A frame with a bad marker, received before lock, restarts the good-frame count, so lock needs 8 new consecutive good frames.
- R4: Once locked, lock is lost on the 4th consecutive bad-marker frame. A good-marker frame arriving before the 4th bad one clears the bad count, and lock is kept.
- R5: `dec_vld` is high only for frames that have a good marker and arrive while the link is locked. Bad-marker frames never produce `dec_vld`, even while locked.
- R6: Channel A word `a_word` equals frame bits 17:9: the tag in bits 8:7 of the word and the code in bits 6:0.
- R7: Channel B word `b_word` equals frame bits 8:0, with the same tag and code placement.
- R8: On a valid frame, a channel's error bit is 1 exactly when its tag differs from (previous valid tag + 1) mod 4. The two channels are checked independently. After an error, the offending tag becomes the new reference.
- R9: The first valid frame after lock is gained never flags a tag error, because there is no reference yet.
- R10: Outputs appear one clock after the frame is presented. A cycle with `frm_vld` low produces `dec_vld` low and leaves the lock state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_vld | input | 1 | A frame is present on `frame` this cycle |
| frame | input | 20 | Deserialized frame |
| locked | output | 1 | Frame alignment held |
| dec_vld | output | 1 | Decoded words valid |
| a_word | output | 9 | Channel A tag and code |
| b_word | output | 9 | Channel B tag and code |
| a_err | output | 1 | Channel A tag rotation error |
| b_err | output | 1 | Channel B tag rotation error |

## Verification
The bench acquires lock with a run of clean frames whose codes differ between channels, so a swapped or shifted field shows at once. It then breaks the tag rotation on one channel only; this separates per-channel checking from a shared flag and shows whether the block re-synchronizes to the new tag. Runs of three and of four bad markers separate keeping lock from losing it. A bad marker placed inside an acquisition run shows whether the good-frame count restarts or merely pauses. An idle cycle checks that a missing frame neither clears lock nor produces output.

// File: rtl/fe_frame_pkg.sv
package fe_frame_pkg;
  localparam int FRAME_W = 20;
  localparam int CODE_W  = 7;
  localparam int TAG_W   = 2;
  localparam int WORD_W  = CODE_W + TAG_W;

  typedef logic [WORD_W-1:0] chan_word_t;

  function automatic logic marker_good(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1 -: 2] == 2'b10;
  endfunction

  function automatic chan_word_t field_a(input logic [FRAME_W-1:0] f);
    return f[2*WORD_W-1 -: WORD_W];
  endfunction

  function automatic chan_word_t field_b(input logic [FRAME_W-1:0] f);
    return f[WORD_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input chan_word_t w);
    return w[WORD_W-1 -: TAG_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_succ(input logic [TAG_W-1:0] t);
    return t + 1'b1;
  endfunction
endpackage

// File: rtl/fe_lock_tracker.sv
module fe_lock_tracker #(
  parameter int LOCK_RUN = 8,
  parameter int LOSS_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_vld,
  input  logic mk_ok,
  output logic lock_q,
  output logic lock_next
);
  localparam int CW = $clog2(LOCK_RUN + LOSS_RUN + 1);
  localparam logic [CW-1:0] LR = CW'(LOCK_RUN);
  localparam logic [CW-1:0] LS = CW'(LOSS_RUN);

  logic [CW-1:0] good_cnt, bad_cnt, good_nx, bad_nx;

  always_comb begin
    good_nx   = good_cnt;
    bad_nx    = bad_cnt;
    lock_next = lock_q;
    if (frm_vld) begin
      if (!lock_q) begin
        bad_nx  = '0;
        good_nx = mk_ok ? good_cnt + 1'b1 : '0;
        if (mk_ok && (good_cnt + 1'b1 == LR)) begin
          lock_next = 1'b1;
          good_nx   = '0;
        end
      end else begin
        good_nx = '0;
        bad_nx  = mk_ok ? '0 : bad_cnt + 1'b1;
        if (!mk_ok && (bad_cnt + 1'b1 == LS)) begin
          lock_next = 1'b0;
          bad_nx    = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good_cnt <= '0;
      bad_cnt  <= '0;
      lock_q   <= 1'b0;
    end else begin
      good_cnt <= good_nx;
      bad_cnt  <= bad_nx;
      lock_q   <= lock_next;
    end
  end

  assert_good_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    good_cnt < LR);
  assert_bad_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt < LS);
endmodule

// File: rtl/fe_tag_checker.sv
module fe_tag_checker
  import fe_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             clear,
  input  logic [TAG_W-1:0] tag_in,
  output logic             mismatch
);
  logic             has_ref;
  logic [TAG_W-1:0] ref_tag;

  assign mismatch = take && has_ref && (tag_in != tag_succ(ref_tag));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      has_ref <= 1'b0;
      ref_tag <= '0;
    end else if (take) begin
      has_ref <= 1'b1;
      ref_tag <= tag_in;
    end
  end

  assert_ref_follows_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear) |=> (has_ref && ref_tag == $past(tag_in)));
endmodule

// File: rtl/fe_frame_decoder.sv
module fe_frame_decoder
  import fe_frame_pkg::*;
#(
  parameter int LOCK_RUN = 8,
  parameter int LOSS_RUN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_vld,
  input  logic [FRAME_W-1:0] frame,
  output logic               locked,
  output logic               dec_vld,
  output logic [WORD_W-1:0]  a_word,
  output logic [WORD_W-1:0]  b_word,
  output logic               a_err,
  output logic               b_err
);
  logic       mk_ok, lock_q, lock_next, take;
  chan_word_t words [2];
  logic [1:0] mism;

  assign mk_ok    = marker_good(frame);
  assign words[0] = field_a(frame);
  assign words[1] = field_b(frame);
  assign take     = frm_vld && mk_ok && lock_next;

  fe_lock_tracker #(.LOCK_RUN(LOCK_RUN), .LOSS_RUN(LOSS_RUN)) u_lock (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .mk_ok(mk_ok),
    .lock_q(lock_q), .lock_next(lock_next)
  );

  for (genvar c = 0; c < 2; c++) begin : g_chan
    fe_tag_checker u_tag (
      .clk(clk), .rst_n(rst_n), .take(take), .clear(!lock_next),
      .tag_in(tag_of(words[c])), .mismatch(mism[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_vld <= 1'b0;
      a_word  <= '0;
      b_word  <= '0;
      a_err   <= 1'b0;
      b_err   <= 1'b0;
    end else begin
      dec_vld <= take;
      a_err   <= mism[0];
      b_err   <= mism[1];
      if (take) begin
        a_word <= words[0];
        b_word <= words[1];
      end
    end
  end

  assign locked = lock_q;

  assert_valid_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> locked);
  assert_err_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_err || b_err) |-> dec_vld);
  assert_lock_on_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frm_vld && mk_ok));
  assert_unlock_on_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(frm_vld && !mk_ok));
  assert_word_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (a_word == $past(frame[2*WORD_W-1 -: WORD_W]) && b_word == $past(frame[WORD_W-1:0])));
  assert_first_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (!a_err && !b_err));
endmodule

// File: tb/fe_frame_decoder_test.sv
module fe_frame_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_vld = 1'b0;
  logic [19:0] frame = '0;
  logic        locked, dec_vld, a_err, b_err;
  logic [8:0]  a_word, b_word;

  int checks = 0;
  int errors = 0;
  logic [1:0] tag_a = 2'd0;
  logic [1:0] tag_b = 2'd2;

  always #4 clk = ~clk;

  fe_frame_decoder uut (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frame(frame),
    .locked(locked), .dec_vld(dec_vld), .a_word(a_word), .b_word(b_word),
    .a_err(a_err), .b_err(b_err)
  );

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: run did not complete, got hang, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [19:0] mk(input logic [1:0] ta, input logic [6:0] ca,
                                     input logic [1:0] tb, input logic [6:0] cb,
                                     input logic good);
    return {good ? 2'b10 : 2'b01, ta, ca, tb, cb};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic v, input logic [19:0] f);
    @(negedge clk);
    frm_vld = v;
    frame   = f;
    @(posedge clk);
    #2;
  endtask

  task automatic send_good(input logic [6:0] ca, input logic [6:0] cb);
    tag_a = tag_a + 2'd1;
    tag_b = tag_b + 2'd1;
    push(1'b1, mk(tag_a, ca, tag_b, cb, 1'b1));
  endtask

  task automatic t_reset;
    chk("R1 locked", locked, 0);
    chk("R1 dec_vld", dec_vld, 0);
    chk("R1 errs", {a_err, b_err}, 0);
    chk("R1 words", {a_word, b_word}, 0);
  endtask

  task automatic t_acquire;
    for (int i = 0; i < 7; i++) begin
      send_good(7'(i + 3), 7'(100 - i));
      chk("R2 not yet locked", locked, 0);
      chk("R5 no valid unlocked", dec_vld, 0);
    end
    send_good(7'h55, 7'h2a);
    chk("R2 locked on 8th", locked, 1);
    chk("R2 first valid", dec_vld, 1);
    chk("R9 no err first", {a_err, b_err}, 0);
    chk("R6 chan A", a_word, {tag_a, 7'h55});
    chk("R7 chan B", b_word, {tag_b, 7'h2a});
  endtask

  task automatic t_rotation;
    send_good(7'h11, 7'h66);
    chk("R8 clean rotation", {a_err, b_err}, 0);
    chk("R6 chan A next", a_word, {tag_a, 7'h11});
    tag_a = tag_a + 2'd2;
    tag_b = tag_b + 2'd1;
    push(1'b1, mk(tag_a, 7'h01, tag_b, 7'h02, 1'b1));
    chk("R8 A err", a_err, 1);
    chk("R8 B clean", b_err, 0);
    chk("R7 chan B value", b_word, {tag_b, 7'h02});
    send_good(7'h03, 7'h04);
    chk("R8 resync", {a_err, b_err}, 0);
    tag_b = tag_b + 2'd3;
    tag_a = tag_a + 2'd1;
    push(1'b1, mk(tag_a, 7'h05, tag_b, 7'h06, 1'b1));
    chk("R8 B err only", {a_err, b_err}, 2'b01);
  endtask

  task automatic t_idle;
    push(1'b0, mk(2'd0, 7'h7f, 2'd0, 7'h7f, 1'b0));
    chk("R10 idle no valid", dec_vld, 0);
    chk("R10 idle keeps lock", locked, 1);
    send_good(7'h09, 7'h0a);
    chk("R10 after idle valid", dec_vld, 1);
    chk("R10 after idle no err", {a_err, b_err}, 0);
  endtask

  task automatic t_short_loss;
    for (int i = 0; i < 3; i++) begin
      push(1'b1, mk(2'd0, 7'h00, 2'd0, 7'h00, 1'b0));
      chk("R5 bad marker no valid", dec_vld, 0);
      chk("R4 lock kept", locked, 1);
    end
    send_good(7'h12, 7'h13);
    chk("R4 good restores count", dec_vld, 1);
    chk("R8 tag ref kept", {a_err, b_err}, 0);
    for (int i = 0; i < 3; i++) begin
      push(1'b1, mk(2'd0, 7'h00, 2'd0, 7'h00, 1'b0));
      chk("R4 lock kept again", locked, 1);
    end
    push(1'b1, mk(2'd0, 7'h00, 2'd0, 7'h00, 1'b0));
    chk("R4 lock lost on 4th", locked, 0);
    chk("R5 no valid after loss", dec_vld, 0);
  endtask

  task automatic t_restart;
    for (int i = 0; i < 5; i++) send_good(7'h20, 7'h21);
    push(1'b1, mk(2'd0, 7'h00, 2'd0, 7'h00, 1'b0));
    for (int i = 0; i < 7; i++) begin
      send_good(7'h22, 7'h23);
      chk("R3 count restarted", locked, 0);
    end
    tag_a = tag_a + 2'd2;
    tag_b = tag_b + 2'd3;
    push(1'b1, mk(tag_a, 7'h31, tag_b, 7'h32, 1'b1));
    chk("R3 relock on 8th", locked, 1);
    chk("R9 no err after relock", {a_err, b_err}, 0);
    chk("R6 word after relock", a_word, {tag_a, 7'h31});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_acquire();
    t_rotation();
    t_idle();
    t_short_loss();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule